// File: doc/BRIEF.md
# TDM Port Alarm Latch and Service Request Bank

This block keeps the alarm state of every port of a multi-port TDM circuit-emulation receiver. Detection logic elsewhere raises one-cycle event pulses: loss of signal, an output buffer fault in unstructured mode, an output buffer fault in structured mode, a structured simple underrun, and a structured permanent underrun. Each pulse sets a sticky status bit. The bit stays set until software writes a zero to it. Each status bit has its own enable bit. The enabled alarms of all ports are merged into one registered service request line for the host.

For each port the block also keeps the channel number of the latest simple underrun and a 32-bit map of the channels that have had a permanent underrun. The channel map is read and cleared through two 16-bit words. A per-port control word arms the two underrun conditions. Writing the control word also unlocks the clearing of the loss-of-signal bit, which cannot be cleared until that word has been written once since reset.

Software reaches all registers through a flat 16-bit write port and a combinational read port. The address is `{port, select}`.

Top module: `tdm_alarm_bank`

## Requirements
- R1: After reset, every status word reads 0x0040 (loss-of-signal status set, everything else zero). Every control word and every channel-map word reads 0x0000, and `srv_req` is 0.
- R2: An event pulse on `ev_los`, `ev_udt_buf` or `ev_sdt_buf` of a port sets the matching status bit at the next clock edge. A set status bit stays set in every cycle with no status write to that port.
- R3: A status write clears each status bit whose data bit is 0. A data bit of 1 leaves its status bit unchanged.
- R4: A status write stores data bits 4:0 as the enables. `srv_req` is 1 in the cycle after any port has a status bit set together with its enable, and 0 in the cycle after no port has such a pair.
- R5: A write of 0 to the loss-of-signal status bit is ignored until the control word of that port has been written in an earlier cycle since reset.
- R6: Control word bit 0 arms simple underrun and bit 1 arms permanent underrun. Both are readable, and all other control bits read 0. An underrun event sets its status bit only when its arming bit is 1.
- R7: Status bits 15:11 hold the channel given with the most recent `ev_simple` pulse of that port. This field updates whether or not simple underrun is armed, and writes cannot change it.
- R8: An `ev_perm` pulse sets bit `perm_chan` of the port's 32-bit channel map, whether or not permanent underrun is armed. Select 2 reads channels 15:0 and select 3 reads channels 31:16. Writing 0 to a map bit clears it, and writing 1 leaves it unchanged.
- R9: When an event and a status write that clears the same bit arrive in the same cycle, the bit ends up set.
- R10: `reg_addr` = {port, select}, with select 0 control, 1 status, 2 map low and 3 map high. The status word layout is: enables in bits 4:0 and status in bits 10:6, each ordered loss of signal, unstructured buffer, structured buffer, permanent underrun, simple underrun from bit 0 upward. Bit 5 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_los | input | NUM_PORTS | Loss-of-signal event pulse per port |
| ev_udt_buf | input | NUM_PORTS | Unstructured output buffer fault pulse per port |
| ev_sdt_buf | input | NUM_PORTS | Structured output buffer fault pulse per port |
| ev_simple | input | NUM_PORTS | Simple underrun event pulse per port |
| simple_chan | input | NUM_PORTS*5 | Channel of the simple underrun, 5 bits per port |
| ev_perm | input | NUM_PORTS | Permanent underrun event pulse per port |
| perm_chan | input | NUM_PORTS*5 | Channel of the permanent underrun, 5 bits per port |
| reg_addr | input | PORT_W+2 | Register address {port, select} |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data |
| srv_req | output | 1 | Registered summary service request |

## Verification
The directed patterns each separate one rule from its neighbours:
- A zero write before and after the control word tells the locked loss-of-signal bit apart from a plain sticky bit.
- An all-ones write shows that ones do not clear.
- Underrun pulses on an unarmed port show that the channel field and the channel map update while the status bits do not.
- An event together with a clearing write in the same cycle shows which one wins.

Constrained random traffic then mixes events, channels and writes to every register of every port. After each cycle the bench compares `srv_req` and one random register against a bench model. This catches wrong cross-port address decoding and wrong timing of the service request.

// File: rtl/tdm_alarm_pkg.sv
package tdm_alarm_pkg;

    localparam int DATA_W  = 16;
    localparam int CHAN_N  = 32;
    localparam int CHAN_W  = $clog2(CHAN_N);
    localparam int SEL_W   = 2;
    localparam int ALARM_N = 5;
    localparam int EN_LSB  = 0;
    localparam int ST_LSB  = 6;
    localparam int CH_LSB  = 11;
    localparam int HALF    = CHAN_N / 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL   = 2'd0,
        SEL_STAT   = 2'd1,
        SEL_MAP_LO = 2'd2,
        SEL_MAP_HI = 2'd3
    } reg_sel_e;

    // bit 0 upward: los, udt_buf, sdt_buf, perm, simple
    typedef struct packed {
        logic simple;
        logic perm;
        logic sdt_buf;
        logic udt_buf;
        logic los;
    } alarm_vec_t;

    typedef struct packed {
        logic arm_perm;
        logic arm_simple;
    } arm_cfg_t;

    localparam alarm_vec_t ALARM_RST = alarm_vec_t'(5'b00001);

    function automatic logic [DATA_W-1:0] pack_status(alarm_vec_t en,
                                                      alarm_vec_t st,
                                                      logic [CHAN_W-1:0] ch);
        return {ch, st, 1'b0, en};
    endfunction

    // keep bits from a zero-to-clear write; a locked los bit is always kept
    function automatic alarm_vec_t apply_clear(alarm_vec_t cur,
                                               logic [ALARM_N-1:0] keep,
                                               logic los_locked);
        alarm_vec_t k;
        k = alarm_vec_t'(keep);
        if (los_locked) k.los = 1'b1;
        return alarm_vec_t'(cur & k);
    endfunction

endpackage

// File: rtl/tdm_alarm_port.sv
module tdm_alarm_port
    import tdm_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  alarm_vec_t        ev_i,
    input  logic [CHAN_W-1:0] simple_ch_i,
    input  logic [CHAN_W-1:0] perm_ch_i,
    input  logic              wr_i,
    input  reg_sel_e          sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output alarm_vec_t        st_o,
    output alarm_vec_t        en_o
);

    arm_cfg_t          arm_q;
    logic              cfg_done_q;
    alarm_vec_t        en_q, st_q;
    logic [CHAN_W-1:0] last_ch_q;
    logic [CHAN_N-1:0] map_q;

    alarm_vec_t        set_v, st_d;
    logic [CHAN_N-1:0] map_keep, map_set;
    logic              wr_stat, wr_ctrl;

    assign wr_stat = wr_i && (sel_i == SEL_STAT);
    assign wr_ctrl = wr_i && (sel_i == SEL_CTRL);

    always_comb begin
        set_v        = ev_i;
        set_v.simple = ev_i.simple & arm_q.arm_simple;
        set_v.perm   = ev_i.perm & arm_q.arm_perm;
        st_d         = wr_stat ? apply_clear(st_q, wdata_i[ST_LSB +: ALARM_N], !cfg_done_q)
                               : st_q;
        st_d         = alarm_vec_t'(st_d | set_v);
    end

    always_comb begin
        map_keep = '1;
        if (wr_i && sel_i == SEL_MAP_LO) map_keep[HALF-1:0]      = wdata_i;
        if (wr_i && sel_i == SEL_MAP_HI) map_keep[CHAN_N-1:HALF] = wdata_i;
        map_set  = ev_i.perm ? (CHAN_N'(1) << perm_ch_i) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q      <= '0;
            cfg_done_q <= 1'b0;
            en_q       <= '0;
            st_q       <= ALARM_RST;
            last_ch_q  <= '0;
            map_q      <= '0;
        end else begin
            if (wr_ctrl) begin
                arm_q      <= arm_cfg_t'(wdata_i[1:0]);
                cfg_done_q <= 1'b1;
            end
            if (wr_stat) en_q <= alarm_vec_t'(wdata_i[EN_LSB +: ALARM_N]);
            st_q  <= st_d;
            if (ev_i.simple) last_ch_q <= simple_ch_i;
            map_q <= (map_q & map_keep) | map_set;
        end
    end

    always_comb begin
        unique case (sel_i)
            SEL_CTRL:   rdata_o = {{(DATA_W-2){1'b0}}, arm_q};
            SEL_STAT:   rdata_o = pack_status(en_q, st_q, last_ch_q);
            SEL_MAP_LO: rdata_o = map_q[HALF-1:0];
            default:    rdata_o = map_q[CHAN_N-1:HALF];
        endcase
    end

    assign st_o = st_q;
    assign en_o = en_q;

endmodule

// File: rtl/tdm_alarm_summary.sv
module tdm_alarm_summary
    import tdm_alarm_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_PORTS*ALARM_N-1:0] st_flat_i,
    input  logic [NUM_PORTS*ALARM_N-1:0] en_flat_i,
    output logic                         srv_o
);

    logic pend;
    assign pend = |(st_flat_i & en_flat_i);

    always_ff @(posedge clk) begin
        if (rst) srv_o <= 1'b0;
        else     srv_o <= pend;
    end

endmodule

// File: rtl/tdm_alarm_bank.sv
module tdm_alarm_bank
    import tdm_alarm_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int ADDR_W   = PORT_W + SEL_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_PORTS-1:0]        ev_los,
    input  logic [NUM_PORTS-1:0]        ev_udt_buf,
    input  logic [NUM_PORTS-1:0]        ev_sdt_buf,
    input  logic [NUM_PORTS-1:0]        ev_simple,
    input  logic [NUM_PORTS*CHAN_W-1:0] simple_chan,
    input  logic [NUM_PORTS-1:0]        ev_perm,
    input  logic [NUM_PORTS*CHAN_W-1:0] perm_chan,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic                        reg_wr,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    output logic                        srv_req
);

    logic [PORT_W-1:0]            port_idx;
    reg_sel_e                     sel;
    logic [DATA_W-1:0]            rd_arr [NUM_PORTS];
    logic [NUM_PORTS*ALARM_N-1:0] st_flat, en_flat;

    assign port_idx = reg_addr[ADDR_W-1:SEL_W];
    assign sel      = reg_sel_e'(reg_addr[SEL_W-1:0]);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        alarm_vec_t ev, st, en;
        always_comb begin
            ev.los     = ev_los[p];
            ev.udt_buf = ev_udt_buf[p];
            ev.sdt_buf = ev_sdt_buf[p];
            ev.perm    = ev_perm[p];
            ev.simple  = ev_simple[p];
        end
        tdm_alarm_port u_port (
            .clk         (clk),
            .rst         (rst),
            .ev_i        (ev),
            .simple_ch_i (simple_chan[p*CHAN_W +: CHAN_W]),
            .perm_ch_i   (perm_chan[p*CHAN_W +: CHAN_W]),
            .wr_i        (reg_wr && (port_idx == PORT_W'(p))),
            .sel_i       (sel),
            .wdata_i     (reg_wdata),
            .rdata_o     (rd_arr[p]),
            .st_o        (st),
            .en_o        (en)
        );
        assign st_flat[p*ALARM_N +: ALARM_N] = st;
        assign en_flat[p*ALARM_N +: ALARM_N] = en;
    end

    always_comb begin
        reg_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++)
            if (port_idx == PORT_W'(p)) reg_rdata = rd_arr[p];
    end

    tdm_alarm_summary #(.NUM_PORTS(NUM_PORTS)) u_summary (
        .clk       (clk),
        .rst       (rst),
        .st_flat_i (st_flat),
        .en_flat_i (en_flat),
        .srv_o     (srv_req)
    );

endmodule

// File: rtl/tdm_alarm_checker.sv
module tdm_alarm_checker
    import tdm_alarm_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         reg_wr,
    input logic [ADDR_W-1:0]            reg_addr,
    input logic [NUM_PORTS-1:0]         ev_los,
    input logic [NUM_PORTS-1:0]         ev_udt_buf,
    input logic [NUM_PORTS*ALARM_N-1:0] st_flat,
    input logic [NUM_PORTS*ALARM_N-1:0] en_flat,
    input logic                         srv_req
);

    logic [NUM_PORTS-1:0] cfg_seen;

    always_ff @(posedge clk) begin
        if (rst) cfg_seen <= '0;
        else
            for (int p = 0; p < NUM_PORTS; p++)
                if (reg_wr && reg_addr == ADDR_W'(p * 4)) cfg_seen[p] <= 1'b1;
    end

    // R1: reset clears the service request
    a_r1_srv_reset: assert property (@(posedge clk) rst |=> !srv_req);

    // R4: service request follows enabled status one cycle later
    a_r4_srv_follows: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (srv_req == $past(|(st_flat & en_flat))));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        logic stat_wr;
        assign stat_wr = reg_wr && (reg_addr == ADDR_W'(p * 4 + 1));

        // R5: los cannot be cleared before the control word was written
        a_r5_los_locked: assert property (@(posedge clk) disable iff (rst)
            (!cfg_seen[p] && st_flat[p*ALARM_N]) |=> st_flat[p*ALARM_N]);

        // R9: an event always lands, even against a clearing write
        a_r9_los_set_wins: assert property (@(posedge clk) disable iff (rst)
            ev_los[p] |=> st_flat[p*ALARM_N]);
        a_r9_udt_set_wins: assert property (@(posedge clk) disable iff (rst)
            ev_udt_buf[p] |=> st_flat[p*ALARM_N+1]);

        for (genvar b = 0; b < ALARM_N; b++) begin : g_bit
            // R2: status bits are sticky without a status write
            a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
                (st_flat[p*ALARM_N+b] && !stat_wr) |=> st_flat[p*ALARM_N+b]);
        end
    end

endmodule

bind tdm_alarm_bank tdm_alarm_checker #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .ev_los     (ev_los),
    .ev_udt_buf (ev_udt_buf),
    .st_flat    (st_flat),
    .en_flat    (en_flat),
    .srv_req    (srv_req)
);

// File: tb/tdm_alarm_bank_tb.sv
`timescale 1ns/1ps
module tdm_alarm_bank_tb;

    localparam int NP = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [NP-1:0] ev_los = '0, ev_udt_buf = '0, ev_sdt_buf = '0, ev_simple = '0, ev_perm = '0;
    logic [NP*5-1:0] simple_chan = '0, perm_chan = '0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        srv_req;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [4:0]  m_st [NP];
    logic [4:0]  m_en [NP];
    logic [1:0]  m_arm [NP];
    bit          m_cfg [NP];
    logic [4:0]  m_last [NP];
    logic [31:0] m_map [NP];
    logic        m_srv;

    always #2 clk = ~clk;

    tdm_alarm_bank #(.NUM_PORTS(NP)) u_dut (
        .clk(clk), .rst(rst),
        .ev_los(ev_los), .ev_udt_buf(ev_udt_buf), .ev_sdt_buf(ev_sdt_buf),
        .ev_simple(ev_simple), .simple_chan(simple_chan),
        .ev_perm(ev_perm), .perm_chan(perm_chan),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .srv_req(srv_req)
    );

    function automatic logic [15:0] exp_read(logic [3:0] a);
        int p = a[3:2];
        case (a[1:0])
            2'd0:    return {14'd0, m_arm[p]};
            2'd1:    return {m_last[p], m_st[p], 1'b0, m_en[p]};
            2'd2:    return m_map[p][15:0];
            default: return m_map[p][31:16];
        endcase
    endfunction

    task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int p = 0; p < NP; p++) begin
            m_st[p] = 5'b00001; m_en[p] = '0; m_arm[p] = '0;
            m_cfg[p] = 0; m_last[p] = '0; m_map[p] = '0;
        end
        m_srv = 1'b0;
    endtask

    // advance one clock edge, updating the model from the driven inputs
    task automatic step();
        logic [4:0]  n_st [NP];
        logic [4:0]  n_en [NP];
        logic [1:0]  n_arm [NP];
        bit          n_cfg [NP];
        logic [4:0]  n_last [NP];
        logic [31:0] n_map [NP];
        logic        n_srv = 1'b0;
        for (int p = 0; p < NP; p++) begin
            logic w = reg_wr && (reg_addr[3:2] == p[1:0]);
            logic [4:0] setv = {ev_simple[p] & m_arm[p][0], ev_perm[p] & m_arm[p][1],
                                ev_sdt_buf[p], ev_udt_buf[p], ev_los[p]};
            n_srv = n_srv | (|(m_st[p] & m_en[p]));
            n_st[p] = m_st[p]; n_en[p] = m_en[p]; n_arm[p] = m_arm[p];
            n_cfg[p] = m_cfg[p]; n_last[p] = m_last[p]; n_map[p] = m_map[p];
            if (w && reg_addr[1:0] == 2'd1) begin
                logic [4:0] keep = reg_wdata[10:6];
                if (!m_cfg[p]) keep[0] = 1'b1;
                n_st[p] = n_st[p] & keep;
                n_en[p] = reg_wdata[4:0];
            end
            n_st[p] = n_st[p] | setv;
            if (w && reg_addr[1:0] == 2'd0) begin n_arm[p] = reg_wdata[1:0]; n_cfg[p] = 1; end
            if (w && reg_addr[1:0] == 2'd2) n_map[p][15:0]  = n_map[p][15:0] & reg_wdata;
            if (w && reg_addr[1:0] == 2'd3) n_map[p][31:16] = n_map[p][31:16] & reg_wdata;
            if (ev_perm[p]) n_map[p][perm_chan[p*5 +: 5]] = 1'b1;
            if (ev_simple[p]) n_last[p] = simple_chan[p*5 +: 5];
        end
        @(posedge clk);
        #1;
        for (int p = 0; p < NP; p++) begin
            m_st[p] = n_st[p]; m_en[p] = n_en[p]; m_arm[p] = n_arm[p];
            m_cfg[p] = n_cfg[p]; m_last[p] = n_last[p]; m_map[p] = n_map[p];
        end
        m_srv = n_srv;
    endtask

    task automatic idle();
        reg_wr = 0; ev_los = '0; ev_udt_buf = '0; ev_sdt_buf = '0; ev_simple = '0; ev_perm = '0;
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        idle(); reg_wr = 1; reg_addr = a; reg_wdata = d;
        step(); idle();
    endtask

    task automatic rd(string tag, logic [3:0] a, logic [15:0] exp);
        reg_wr = 0; reg_addr = a; #0.05;
        check_eq(tag, reg_rdata, exp);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7215));
        model_reset();
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1: reset values of all registers
        for (int a = 0; a < 16; a++)
            rd("R1 reset", a[3:0], (a % 4 == 1) ? 16'h0040 : 16'h0000);
        check_eq("R1 srv reset", srv_req, 0);

        // R5: los clear ignored before control write
        wr(4'd1, 16'h0000);
        rd("R5 los locked", 4'd1, 16'h0040);
        wr(4'd0, 16'hFFFF);
        rd("R6 ctrl readback", 4'd0, 16'h0003);
        wr(4'd1, 16'h0000);
        rd("R5 los clear after ctrl", 4'd1, 16'h0000);

        // R2 / R3: set by event, ones do not clear
        ev_udt_buf[0] = 1; step(); idle();
        rd("R2 udt set", 4'd1, 16'h0080);
        wr(4'd1, 16'h07C0);
        rd("R3 write one keeps", 4'd1, 16'h0080);

        // R4: enable and service timing
        wr(4'd1, 16'h07C2);
        check_eq("R4 srv before", srv_req, 0);
        step();
        check_eq("R4 srv raised", srv_req, 1);
        wr(4'd1, 16'h0002);
        check_eq("R4 srv lag", srv_req, 1);
        step();
        check_eq("R4 srv dropped", srv_req, 0);

        // R6 / R7 / R8: unarmed port 1 underruns
        ev_simple[1] = 1; simple_chan[9:5] = 5'd9;
        ev_perm[1] = 1; perm_chan[9:5] = 5'd20;
        step(); idle();
        rd("R6 R7 unarmed status", 4'd5, 16'h4840);
        rd("R8 map hi", 4'd7, 16'h0010);
        rd("R8 map lo", 4'd6, 16'h0000);
        wr(4'd7, 16'hFFEF);
        rd("R8 map clear", 4'd7, 16'h0000);

        // R9: event and clear together on armed port 0
        idle(); ev_simple[0] = 1; simple_chan[4:0] = 5'd31;
        reg_wr = 1; reg_addr = 4'd1; reg_wdata = 16'h0000;
        step(); idle();
        rd("R9 set wins", 4'd1, 16'hFC00);

        // R10: reserved bit and field layout
        wr(4'd9, 16'hFFFF);
        rd("R10 layout", 4'd9, 16'h005F);

        // constrained random traffic
        for (int i = 0; i < 600; i++) begin
            logic [3:0] ra;
            idle();
            for (int p = 0; p < NP; p++) begin
                ev_los[p]     = ($urandom % 16) == 0;
                ev_udt_buf[p] = ($urandom % 12) == 0;
                ev_sdt_buf[p] = ($urandom % 12) == 0;
                ev_simple[p]  = ($urandom % 8) == 0;
                ev_perm[p]    = ($urandom % 8) == 0;
            end
            simple_chan = 20'($urandom);
            perm_chan   = 20'($urandom);
            if (($urandom % 3) == 0) begin
                reg_wr = 1;
                reg_addr = 4'($urandom);
                reg_wdata = 16'($urandom);
            end
            step(); idle();
            check_eq("R4 random srv", srv_req, m_srv);
            ra = 4'($urandom);
            rd("R10 random read", ra, exp_read(ra));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule